// File: doc/BRIEF.md
# Page-Zero/Stack Pair Memory

This block is a tagless on-chip store for the lowest 512 bytes of a 16-bit address space: page 0, used for pointers, and page 1, used for the stack. Nothing has to be looked up to find a byte, because where each byte lives is fixed. The bytes are split into two banks. One bank holds the even addresses and the other holds the odd addresses. Because of this split, any two neighbouring bytes always sit in different banks and can be fetched together in one cycle, whatever the alignment.

There are three ports. A pointer port returns a 16-bit little-endian pair starting at any byte of either page. The second byte comes from the next offset in the same page, so a pointer at offset $FF takes its high byte from offset $00. A byte read port and a byte write port take full 16-bit addresses. Each of these ports reports through a hit flag whether its address falls in pages 0/1, so surrounding logic can steer the access here instead of to external memory.

All reads are synchronous: data appears on the outputs in the cycle after the request. A read of a byte that is being written in the same cycle returns the new value.

Top module: `pz_pair_mem`

## Requirements
- R1: `rd_hit` and `wr_hit` are combinational. Each is 1 exactly when bits 15..9 of its port's address are all zero, which means the address is in $0000..$01FF.
- R2: When `rd_en` is 1 and `rd_hit` is 1, `rd_data` in the next cycle equals the stored byte at `rd_addr[8:0]`. This holds for even and odd addresses in both pages.
- R3: `ptr_addr[8]` selects the page and `ptr_addr[7:0]` is the offset. When `ptr_en` is 1, in the next cycle `ptr_data[7:0]` is the byte at the pointer address and `ptr_data[15:8]` is the byte at the next offset of the same page. This holds for both even and odd (unaligned) pointer addresses.
- R4: A pointer at offset $FF reads its high byte from offset $00 of the same page. So $0FF pairs with $000, and $1FF pairs with $100.
- R5: When `wr_en` is 1 and `wr_hit` is 1, `wr_data` is stored at `wr_addr[8:0]`. A write whose address misses changes no stored byte.
- R6: Write-first: if a byte port read or either byte of a pointer read targets the byte being written in the same cycle, that read returns `wr_data`.
- R7: `rd_data` holds its value when no hitting read is requested, including a read whose address misses. `ptr_data` holds its value when `ptr_en` is 0.
- R8: While `rst_n` is 0, `rd_data` and `ptr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_en | input | 1 | Pointer read request |
| ptr_addr | input | 9 | Pointer address: page bit and offset |
| ptr_data | output | 16 | Pointer pair {high, low}, one cycle after request |
| rd_en | input | 1 | Byte read request |
| rd_addr | input | 16 | Byte read address |
| rd_hit | output | 1 | Byte read address lies in pages 0/1 |
| rd_data | output | 8 | Byte read result, one cycle after request |
| wr_en | input | 1 | Byte write request |
| wr_addr | input | 16 | Byte write address |
| wr_data | input | 8 | Byte to store |
| wr_hit | output | 1 | Write address lies in pages 0/1 |

## Verification
The pointer port is driven with four kinds of addresses:
- Even addresses, where the low byte comes from the even bank.
- Odd addresses, where the bank roles swap.
- The two page-end offsets, which separate a correct same-page wrap from a carry into the next page.
- Addresses whose bytes are being written in the same cycle, which separate write-first from read-old behaviour.

The byte port is driven with hitting and missing addresses, both alone and together with writes to aliasing addresses. This shows whether the hit decode gates stores and whether a missed read leaves the output alone. A long mixed stretch with random concurrent traffic on all three ports is compared every cycle against a behavioural byte-array model.

// File: rtl/pz_pkg.sv
package pz_pkg;
    localparam int PZ_ADDR_W   = 16; // full address width
    localparam int PZ_DATA_W   = 8;  // byte width
    localparam int PZ_REGION_W = 9;  // pages 0 and 1 span 2**9 bytes
    localparam int PZ_NBANK    = 2;  // even and odd banks
endpackage

// File: rtl/pz_hit_dec.sv
module pz_hit_dec #(
    parameter int ADDR_W   = 16,
    parameter int REGION_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Region is the bottom 2**REGION_W bytes: every upper bit clear
    assign hit = ~|addr[ADDR_W-1:REGION_W];
endmodule

// File: rtl/pz_bank.sv
module pz_bank #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter int N_RD   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             wa,
    input  logic [DATA_W-1:0]            wd,
    input  logic [N_RD-1:0]              re,
    input  logic [N_RD-1:0][IDX_W-1:0]   ra,
    output logic [N_RD-1:0][DATA_W-1:0]  q
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[wa] <= wd;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rport
        logic [DATA_W-1:0] q_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r <= '0;
            end else if (re[g]) begin
                // write-first forwarding on a same-index collision
                q_r <= (we && (wa == ra[g])) ? wd : store[ra[g]];
            end
        end
        assign q[g] = q_r;
    end
endmodule

// File: rtl/pz_pair_mem.sv
module pz_pair_mem
    import pz_pkg::*;
#(
    parameter int ADDR_W   = PZ_ADDR_W,
    parameter int DATA_W   = PZ_DATA_W,
    parameter int REGION_W = PZ_REGION_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ptr_en,
    input  logic [REGION_W-1:0]  ptr_addr,
    output logic [2*DATA_W-1:0]  ptr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_hit,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 wr_hit
);
    localparam int OFF_W = REGION_W - 1;  // offset within one page
    localparam int IDX_W = REGION_W - 1;  // index within one bank
    localparam int P_PTR = 0;             // bank read port used by pointer
    localparam int P_BYT = 1;             // bank read port used by byte reads

    pz_hit_dec #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_rd_dec (
        .addr(rd_addr), .hit(rd_hit)
    );
    pz_hit_dec #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_wr_dec (
        .addr(wr_addr), .hit(wr_hit)
    );

    logic wr_go, rd_go;
    assign wr_go = wr_en & wr_hit;
    assign rd_go = rd_en & rd_hit;

    // Pointer pair: low byte at A, high byte at next offset of the same page
    logic [REGION_W-1:0] lo_a, hi_a;
    assign lo_a = ptr_addr;
    assign hi_a = {ptr_addr[REGION_W-1], ptr_addr[OFF_W-1:0] + OFF_W'(1)};

    logic [PZ_NBANK-1:0][1:0]             b_re;
    logic [PZ_NBANK-1:0][1:0][IDX_W-1:0]  b_ra;
    logic [PZ_NBANK-1:0][1:0][DATA_W-1:0] b_q;

    for (genvar b = 0; b < PZ_NBANK; b++) begin : g_bank
        always_comb begin
            // bank b owns addresses whose bit 0 equals b
            b_ra[b][P_PTR] = (lo_a[0] == 1'(b)) ? lo_a[REGION_W-1:1]
                                                : hi_a[REGION_W-1:1];
            b_re[b][P_PTR] = ptr_en;
            b_ra[b][P_BYT] = rd_addr[REGION_W-1:1];
            b_re[b][P_BYT] = rd_go & (rd_addr[0] == 1'(b));
        end

        pz_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_RD(2)) u_bank (
            .clk (clk),
            .rst_n (rst_n),
            .we  (wr_go & (wr_addr[0] == 1'(b))),
            .wa  (wr_addr[REGION_W-1:1]),
            .wd  (wr_data),
            .re  (b_re[b]),
            .ra  (b_ra[b]),
            .q   (b_q[b])
        );
    end

    // Output steering remembers which bank served which byte
    logic ptr_swap_q, rd_odd_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_swap_q <= 1'b0;
            rd_odd_q   <= 1'b0;
        end else begin
            if (ptr_en) ptr_swap_q <= lo_a[0];
            if (rd_go)  rd_odd_q   <= rd_addr[0];
        end
    end

    assign ptr_data = ptr_swap_q ? {b_q[0][P_PTR], b_q[1][P_PTR]}
                                 : {b_q[1][P_PTR], b_q[0][P_PTR]};
    assign rd_data  = rd_odd_q ? b_q[1][P_BYT] : b_q[0][P_BYT];
endmodule

// File: rtl/pz_pair_mem_chk.sv
module pz_pair_mem_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int REGION_W = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ptr_en,
    input logic [REGION_W-1:0] ptr_addr,
    input logic [2*DATA_W-1:0] ptr_data,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic                rd_hit,
    input logic [DATA_W-1:0]   rd_data,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                wr_hit
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(1) << REGION_W;

    logic [REGION_W-1:0] nxt_a;
    assign nxt_a = {ptr_addr[REGION_W-1], ptr_addr[REGION_W-2:0] + (REGION_W-1)'(1)};

    a_r1_rd_hit_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (rd_addr < LIMIT));
    a_r1_wr_miss_range: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |-> (wr_addr >= LIMIT));
    a_r6_byte_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_hit && wr_en && wr_hit && rd_addr == wr_addr)
        |=> rd_data == $past(wr_data));
    a_r6_ptr_hi_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && wr_en && wr_hit && wr_addr[REGION_W-1:0] == nxt_a)
        |=> ptr_data[2*DATA_W-1:DATA_W] == $past(wr_data));
    a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_hit) |=> $stable(rd_data));
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_en |=> $stable(ptr_data));
endmodule

bind pz_pair_mem pz_pair_mem_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_W(REGION_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ptr_en(ptr_en), .ptr_addr(ptr_addr),
    .ptr_data(ptr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_hit(rd_hit),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_hit(wr_hit)
);

// File: tb/tb_pz_pair_mem.sv
module tb_pz_pair_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_en = 1'b0;
    logic [8:0]  ptr_addr = '0;
    logic [15:0] ptr_data;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        rd_hit;
    logic [7:0]  rd_data;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_hit;

    always #5 clk = ~clk;

    pz_pair_mem dut (.*);

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0]  model [512];
    logic [7:0]  exp_rd = '0;
    logic [15:0] exp_ptr = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input logic [8:0] a, input bit we,
                                           input bit wh, input logic [15:0] wa,
                                           input logic [7:0] wd);
        if (we && wh && wa[8:0] == a) return wd;
        return model[a];
    endfunction

    task automatic cyc(input bit pe, input logic [8:0] pa, input bit re,
                       input logic [15:0] ra, input bit we, input logic [15:0] wa,
                       input logic [7:0] wd, input string tag);
        bit rh, wh;
        ptr_en = pe; ptr_addr = pa; rd_en = re; rd_addr = ra;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rh = (ra[15:9] == 7'd0);
        wh = (wa[15:9] == 7'd0);
        #1;
        check({"R1 rd_hit ", tag}, 32'(rd_hit), 32'(rh));
        check({"R1 wr_hit ", tag}, 32'(wr_hit), 32'(wh));
        if (re && rh) exp_rd = byte_at(ra[8:0], we, wh, wa, wd);
        if (pe) exp_ptr = {byte_at({pa[8], pa[7:0] + 8'd1}, we, wh, wa, wd),
                           byte_at(pa, we, wh, wa, wd)};
        if (we && wh) model[wa[8:0]] = wd;
        @(posedge clk);
        @(negedge clk);
        check({"R2 rd_data ", tag}, 32'(rd_data), 32'(exp_rd));
        check({"R3 ptr_data ", tag}, 32'(ptr_data), 32'(exp_ptr));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs zero during reset
        check("R8 rd_data reset", 32'(rd_data), 32'h0);
        check("R8 ptr_data reset", 32'(ptr_data), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: fill both pages through the write port
        for (int i = 0; i < 512; i++)
            cyc(0, 0, 0, 0, 1, 16'(i), 8'((i * 37 + 5) & 255), "R5 fill");

        // R2: byte reads, both banks, both pages
        cyc(0, 0, 1, 16'h0000, 0, 0, 0, "R2 even p0");
        cyc(0, 0, 1, 16'h0033, 0, 0, 0, "R2 odd p0");
        cyc(0, 0, 1, 16'h0142, 0, 0, 0, "R2 even p1");
        cyc(0, 0, 1, 16'h01FF, 0, 0, 0, "R2 top");

        // R3: aligned and unaligned pointers
        cyc(1, 9'h010, 0, 0, 0, 0, 0, "R3 aligned");
        cyc(1, 9'h011, 0, 0, 0, 0, 0, "R3 unaligned");
        cyc(1, 9'h17E, 0, 0, 0, 0, 0, "R3 p1 aligned");
        // R4: same-page wrap
        cyc(1, 9'h0FF, 0, 0, 0, 0, 0, "R4 wrap p0");
        cyc(1, 9'h1FF, 0, 0, 0, 0, 0, "R4 wrap p1");

        // R5: missed write changes nothing, observed via aliased address
        cyc(0, 0, 0, 0, 1, 16'h0203, 8'hA5, "R5 miss write");
        cyc(0, 0, 1, 16'h0003, 0, 0, 0, "R5 alias unchanged");
        cyc(0, 0, 0, 0, 1, 16'hFE44, 8'h5A, "R5 miss high");
        cyc(1, 9'h044, 0, 0, 0, 0, 0, "R5 alias ptr unchanged");

        // R6: write-first on byte and pointer ports
        cyc(0, 0, 1, 16'h0010, 1, 16'h0010, 8'hC3, "R6 byte bypass");
        cyc(1, 9'h00F, 0, 0, 1, 16'h0010, 8'h3C, "R6 ptr hi bypass");
        cyc(1, 9'h0FF, 0, 0, 1, 16'h0000, 8'h77, "R6 R4 wrap bypass");
        cyc(1, 9'h120, 1, 16'h0121, 1, 16'h0120, 8'h99, "R6 ptr lo bypass");

        // R7: outputs hold when idle or on a missed read
        cyc(0, 0, 0, 0, 0, 0, 0, "R7 idle");
        cyc(0, 0, 1, 16'h8000, 0, 0, 0, "R7 miss read");
        cyc(0, 0, 1, 16'h0200, 1, 16'h0051, 8'h12, "R7 miss read with write");

        // Mixed random traffic on all ports
        for (int i = 0; i < 300; i++) begin
            logic [15:0] ra, wa;
            ra = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 512);
            wa = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 512);
            if ($urandom % 3 == 0) wa = ra;
            cyc(1'($urandom), 9'($urandom), 1'($urandom), ra,
                1'($urandom), wa, 8'($urandom), "mix");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule